// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out the multi-word transfers behind stack push, stack pop and the increment-after load-multiple and store-multiple instructions of a small 16-bit-encoded processor. A decoder hands it one start pulse together with an operation code, an 8-bit list of low registers (indices 0 to 7), an extra-register flag, the base register index, and the current base and stack pointer values. The sequencer then moves one 32-bit word per memory transaction. It reads store data from, and writes load results and the final pointer back to, an external register file.

Words move in ascending register order at addresses that rise by 4 per transfer. A push first lowers the stack pointer by the full transfer size. It then stores upward from that point, so the lowest-numbered register lands at the lowest address. The extra flag adds the link register to a push and the program counter to a pop. It has no effect on the load-multiple and store-multiple operations.

Top module: `regblk_seq`

## Requirements
- R1: Listed registers are transferred lowest index first. Each transfer uses an address exactly 4 above the previous one, and the number of memory transactions equals the number of words moved.
- R2: Push (op code 2'b00) stores from address sp_val − 4 × (set list bits + extra flag) upward. It then writes that lowered address to the stack pointer (register index 13).
- R3: On push with the extra flag set, the link register (index 14) is stored after all listed registers, at the highest address.
- R4: Pop (op code 2'b01) loads from sp_val upward. With the extra flag set it loads the program counter (index 15) last, with bit 0 of the loaded word forced to 0. It then writes sp_val + 4 × words moved to index 13.
- R5: Store-multiple (op code 2'b10) stores the listed registers from base_val upward. It always writes base_val + 4 × list count back to the base register, and it ignores the extra flag.
- R6: Load-multiple (op code 2'b11) loads the listed registers from base_val upward and ignores the extra flag. It writes base_val + 4 × list count to the base register only when the base register's own list bit is clear.
- R7: A transfer with no words to move (an empty list and no effective extra register) raises done in the cycle right after start. It makes no memory request and writes no register.
- R8: mem_req, mem_we, mem_addr and mem_wdata stay constant while mem_req is high and mem_ack is low. A word is transferred only in a cycle with both high, and the next request may follow in the very next cycle.
- R9: busy rises in the cycle after an accepted start and stays high through the single cycle in which done is high. A start pulse while busy changes neither the transfer in progress nor its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled only when idle) |
| op | input | 2 | 00 push, 01 pop, 10 store-multiple, 11 load-multiple |
| rlist | input | 8 | Low-register list, bit i selects register i |
| xtra | input | 1 | Adds link register to push / program counter to pop |
| base_idx | input | 3 | Base register index for load/store-multiple |
| base_val | input | 32 | Current base register value |
| sp_val | input | 32 | Current stack pointer value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the sequencer with its default parameters: an 8-bit list, 32-bit words and a 4-bit register index. With those values a full sweep of all 256 lists, under every op code and both extra-flag values, fits easily within the run. The base index rotates with the list, so load-multiple meets the base register both inside and outside its list. Acknowledge delays cycle through 0 to 2 cycles, which covers both back-to-back transfers and stalls. A second start pulse is injected in the middle of many transfers.

// File: rtl/regblk_seq.sv
module regblk_seq #(
  parameter int DW = 32,
  parameter int LW = 8,
  parameter int IW = 4,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  localparam int LIW = $clog2(LW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     op,
  input  logic [LW-1:0]  rlist,
  input  logic           xtra,
  input  logic [LIW-1:0] base_idx,
  input  logic [DW-1:0]  base_val,
  input  logic [DW-1:0]  sp_val,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic [IW-1:0]  rf_rd_idx,
  input  logic [DW-1:0]  rf_rd_data,
  output logic           rf_we,
  output logic [IW-1:0]  rf_wr_idx,
  output logic [DW-1:0]  rf_wr_data,
  output logic           busy,
  output logic           done
);
  localparam int STEP = DW / 8;
  localparam int SSH = $clog2(STEP);
  localparam int CW = $clog2(LW + 2);
  localparam logic [1:0] OP_PUSH = 2'd0, OP_POP = 2'd1, OP_LDM = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WB} st_t;
  st_t st;

  logic [1:0]     op_q;
  logic [LW-1:0]  pend;
  logic           xp, wb_q;
  logic [LIW-1:0] bidx_q;
  logic [DW-1:0]  addr_q, fin_q;

  logic [CW-1:0]  cnt;
  logic [DW-1:0]  span, sa, fin_n;
  logic [LIW-1:0] low;

  always_comb begin
    cnt = CW'(xtra && !op[1]);
    for (int i = 0; i < LW; i++) cnt = cnt + CW'(rlist[i]);
  end

  assign span = DW'(cnt) << SSH;

  always_comb begin
    case (op)
      OP_PUSH: begin sa = sp_val - span; fin_n = sp_val - span; end
      OP_POP:  begin sa = sp_val;        fin_n = sp_val + span; end
      default: begin sa = base_val;      fin_n = base_val + span; end
    endcase
  end

  always_comb begin
    low = '0;
    for (int i = LW - 1; i >= 0; i--) if (pend[i]) low = LIW'(i);
  end

  wire            empty   = (cnt == '0);
  wire            have    = |pend;
  wire [LW-1:0]   pend_n  = pend & ~(LW'(1) << low);
  wire            last    = have ? (pend_n == '0 && !xp) : 1'b1;
  wire            pc_slot = !have && (op_q == OP_POP);
  wire [IW-1:0]   cur_idx = have ? IW'(low) : ((op_q == OP_PUSH) ? IW'(LR_IDX) : IW'(PC_IDX));

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_WB);
  assign mem_req    = (st == S_XFER);
  assign mem_we     = mem_req && !op_q[0];
  assign mem_addr   = addr_q;
  assign rf_rd_idx  = cur_idx;
  assign mem_wdata  = rf_rd_data;
  assign rf_we      = (mem_req && mem_ack && op_q[0]) || (done && wb_q);
  assign rf_wr_idx  = done ? (op_q[1] ? IW'(bidx_q) : IW'(SP_IDX)) : cur_idx;
  assign rf_wr_data = done ? fin_q : (pc_slot ? {mem_rdata[DW-1:1], 1'b0} : mem_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      pend   <= '0;
      xp     <= 1'b0;
      wb_q   <= 1'b0;
      bidx_q <= '0;
      addr_q <= '0;
      fin_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          pend   <= rlist;
          xp     <= xtra && !op[1];
          bidx_q <= base_idx;
          addr_q <= sa;
          fin_q  <= fin_n;
          wb_q   <= !empty && !(op == OP_LDM && rlist[base_idx]);
          st     <= empty ? S_WB : S_XFER;
        end
        S_XFER: if (mem_ack) begin
          if (have) pend <= pend_n;
          else      xp   <= 1'b0;
          addr_q <= addr_q + DW'(STEP);
          if (last) st <= S_WB;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regblk_seq_chk.sv
module regblk_seq_chk #(
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int PC_IDX = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          rf_we,
  input logic [IW-1:0] rf_wr_idx,
  input logic [DW-1:0] rf_wr_data,
  input logic          busy,
  input logic          done
);
  localparam int STEP = DW / 8;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req || mem_addr == $past(mem_addr) + DW'(STEP)); // R1
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && rf_wr_idx == IW'(PC_IDX) |-> !rf_wr_data[0]); // R4
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !rf_we); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !rf_we && !done); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R9
endmodule

bind regblk_seq regblk_seq_chk #(.DW(DW), .IW(IW), .PC_IDX(PC_IDX)) u_chk (.*);

// File: tb/regblk_seq_test.sv
module regblk_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SPV = 32'h0000_0200;
  localparam logic [31:0] BASEV = 32'h0000_0100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = '0;
  logic [7:0] rlist = '0;
  logic xtra = 1'b0;
  logic [2:0] base_idx = '0;
  logic [31:0] base_val = '0, sp_val = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0] rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data;
  logic rf_we, busy, done;

  logic [31:0] rf [16];
  logic [31:0] mm [256];
  logic [31:0] exp_addr [10];
  logic [31:0] exp_wd [10];
  logic exp_we;
  int tx_n, wcnt, iter, checks = 0, errors = 0, cycles = 0;
  string cur_tag;
  logic ack_nxt;

  always #(CLK_PERIOD/2) clk = ~clk;

  regblk_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rlist(rlist), .xtra(xtra),
    .base_idx(base_idx), .base_val(base_val), .sp_val(sp_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .busy(busy), .done(done));

  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) if (rf_we) rf[rf_wr_idx] <= rf_wr_data;

  function automatic logic [31:0] rinit(int i);
    return 32'h5000_0000 | (32'(iter & 16'hFFFF) << 8) | 32'(i * 17);
  endfunction

  function automatic logic [31:0] minit(int k);
    return 32'hA500_0000 | (32'(iter & 16'hFFFF) << 8) | 32'(k);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    ack_nxt = 1'b0;
    if (rst_n && mem_req) begin
      if (wcnt == 0) begin
        ack_nxt = 1'b1;
        mem_rdata = mm[mem_addr[9:2]];
        if (tx_n < 10) begin
          check(mem_addr == exp_addr[tx_n], {cur_tag, " R1 address"}, mem_addr, exp_addr[tx_n]);
          check(mem_we == exp_we, {cur_tag, " R8 direction"}, 32'(mem_we), 32'(exp_we));
          if (exp_we) check(mem_wdata == exp_wd[tx_n], {cur_tag, " store data"}, mem_wdata, exp_wd[tx_n]);
        end
        if (mem_we) mm[mem_addr[9:2]] <= mem_wdata;
        tx_n++;
        wcnt = (tx_n + iter) % 3;
      end else wcnt--;
    end
    mem_ack = ack_nxt;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [7:0] l, input logic x, input logic [2:0] b, input logic poke);
    logic [31:0] e [16];
    logic [31:0] sa;
    int n, words, t, cyc;
    logic xe;
    for (int i = 0; i < 16; i++) rf[i] <= rinit(i);
    rf[13] <= SPV;
    rf[b] <= BASEV;
    for (int k = 0; k < 256; k++) mm[k] <= minit(k);
    for (int i = 0; i < 16; i++) e[i] = rinit(i);
    e[13] = SPV;
    e[b] = BASEV;
    n = 0;
    for (int i = 0; i < 8; i++) n += int'(l[i]);
    xe = x && !o[1];
    words = n + int'(xe);
    case (o)
      2'd0: begin sa = SPV - 32'(4 * words); cur_tag = "R2 push"; end
      2'd1: begin sa = SPV; cur_tag = "R4 pop"; end
      2'd2: begin sa = BASEV; cur_tag = "R5 stm"; end
      default: begin sa = BASEV; cur_tag = "R6 ldm"; end
    endcase
    exp_we = !o[0];
    t = 0;
    for (int i = 0; i < 8; i++) if (l[i]) begin
      exp_addr[t] = sa + 32'(4 * t);
      exp_wd[t] = e[i];
      if (o[0]) e[i] = minit(int'(exp_addr[t][9:2]));
      t++;
    end
    if (xe) begin
      exp_addr[t] = sa + 32'(4 * t);
      exp_wd[t] = e[14];
      if (o == 2'd1) e[15] = minit(int'(exp_addr[t][9:2])) & ~32'd1;
    end
    if (o == 2'd0) e[13] = sa;
    else if (o == 2'd1) e[13] = SPV + 32'(4 * words);
    else if (o == 2'd2) e[b] = BASEV + 32'(4 * n);
    else if (!l[b]) e[b] = BASEV + 32'(4 * n);

    tx_n = 0;
    wcnt = 0;
    op = o; rlist = l; xtra = x; base_idx = b; base_val = BASEV; sp_val = SPV;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, {cur_tag, " R9 busy after start"}, 32'(busy), 32'd1);
    if (poke && !done) begin
      op = ~o; rlist = ~l; xtra = ~x; base_idx = ~b; base_val = 32'h0; sp_val = 32'h0;
      start = 1'b1;
    end
    while (!done && cyc < 200) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (cyc >= 200) check(1'b0, {cur_tag, " R9 completion"}, 32'(cyc), 32'd0);
    if (words == 0) check(cyc == 1 && tx_n == 0, {cur_tag, " R7 empty completes at once"}, 32'(cyc), 32'd1);
    @(negedge clk);
    check(!busy && !done, {cur_tag, " R9 idle after done"}, {30'd0, busy, done}, 32'd0);
    check(tx_n == words, {cur_tag, " R1 transaction count"}, 32'(tx_n), 32'(words));
    for (int i = 0; i < 16; i++)
      check(rf[i] == e[i], $sformatf("%s reg %0d%s", cur_tag, i, (i == 14 || i == 15) ? " R3/R4 extra" : ""), rf[i], e[i]);
  endtask

  initial begin
    iter = 0;
    tx_n = 0;
    wcnt = 0;
    cur_tag = "reset";
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !rf_we, "R9 reset state", {28'd0, busy, done, mem_req, rf_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 2; x++)
        for (int l = 0; l < 256; l++) begin
          iter++;
          run_op(2'(o), 8'(l), 1'(x), 3'((l + x + o) % 8), (iter % 3) == 0);
        end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule